// File: doc/BRIEF.md
# HDLC Receive Packet Controller

This block receives a serial bit stream and extracts HDLC frames from it. A bit is taken on every clock cycle in which the bit-enable strobe is high. The block finds the flag pattern and removes stuffed zeros. It packs the remaining bits into bytes and writes each byte to a receive FIFO through a write strobe. The block does not buffer bytes itself. When the FIFO reports full, the block drops the rest of the frame.

A frame check sequence is computed over every data bit. The closing flag decides the result, good or bad. Two sticky status bits report frame activity: one for the start of a packet and one for its end. An end-reason code is held beside the end bit and tells which case occurred: good completion, CRC failure, FIFO overrun or abort. Software clears both status bits with a read-clear pulse. A separate control bit resets the receiver, but only on its 0-to-1 transition.

Top module: `hdlc_rx_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no line activity, `sts_start`, `sts_end` and `fifo_wr` are 0 and `end_code` is 0.
- R2: When the receiver is hunting, a flag octet 0x7E sets `sts_start`. Bits are taken least significant bit first, only in cycles where `bit_en` is 1.
- R3: A 0 bit that follows five consecutive 1 bits inside a frame is discarded. Every other data bit is packed least significant bit first into bytes. Each byte is written to the FIFO, including the two FCS bytes.
- R4: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1. The shift register is preset to all ones. When a frame of at least one data bit is closed by a flag, the residue is checked. If the residue equals 0xF0B8 and the frame ends on a byte boundary, `sts_end` is set with `end_code` 0 (good).
- R5: A frame closed by a flag with any other residue, or off a byte boundary, sets `sts_end` with `end_code` 1 (CRC error).
- R6: A byte can complete while `fifo_full` is 1. In that case the byte is not written, `sts_end` is set with `end_code` 2 (overrun), and no further bytes of that frame are written.
- R7: Seven consecutive 1 bits inside a frame that has carried data set `sts_end` with `end_code` 3 (abort). A run of 1 bits on an idle line sets no status bit.
- R8: `sts_start` and `sts_end` keep their value until a `sts_clear` pulse clears them. In the same cycle, a new event wins over a clear.
- R9: A 0-to-1 transition of `rx_reset_ctl` clears the frame state and both status bits. Holding `rx_reset_ctl` high has no further effect on reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_reset_ctl | input | 1 | Receiver reset control, acts on its rising edge |
| bit_en | input | 1 | Line bit strobe |
| bit_in | input | 1 | Line bit |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Byte written to the receive FIFO |
| sts_clear | input | 1 | Read-clear pulse for the status bits |
| sts_start | output | 1 | Sticky packet-start status |
| sts_end | output | 1 | Sticky packet-end status |
| end_code | output | 2 | Reason for the last end: 0 good, 1 CRC, 2 overrun, 3 abort |

## Verification
The assertions check several rules on every cycle:
- a FIFO write never follows a full indication;
- a new start status always traces back to a flag event;
- an overrun end only follows `fifo_full`;
- status bits fall only after a clear or a control reset;
- the control edge empties the status.

Other behaviours can only be shown by the bench scenarios:
- the destuffed byte values;
- the CRC residue decision over complete frames with 1-runs that force stuffing;
- the abort-versus-idle distinction;
- the drop of the rest of a frame after an overrun;
- the edge-only reaction to the control bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_FRAME = 2'd1,
    ST_DROP  = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    END_GOOD = 2'd0,
    END_CRC  = 2'd1,
    END_OVR  = 2'd2,
    END_ABT  = 2'd3
  } end_code_e;

endpackage

// File: rtl/hdlc_rx_destuff.sv
// Flag / abort detection, zero removal and a flag-length delay line so that
// the bits of a closing flag never reach the byte assembler.
module hdlc_rx_destuff #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic bit_en,
  input  logic bit_in,
  output logic d_valid,
  output logic d_bit,
  output logic flag_evt,
  output logic abort_evt
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int DL_LEN    = FLAG_RUN + 1;
  localparam int ONES_W    = $clog2(ABORT_RUN + 1);
  localparam int OCC_W     = $clog2(DL_LEN + 1);

  logic [ONES_W-1:0] ones_q, ones_n;
  logic [OCC_W-1:0]  occ_q, occ_n;
  logic [DL_LEN-1:0] dl_q, dl_n;
  logic              is_flag, is_abort, is_stuff, is_data;
  logic              dv_n, db_n;

  always_comb begin
    is_flag  = bit_en && !bit_in && (ones_q == ONES_W'(FLAG_RUN));
    is_abort = bit_en &&  bit_in && (ones_q == ONES_W'(FLAG_RUN));
    is_stuff = bit_en && !bit_in && (ones_q == ONES_W'(STUFF_RUN));
    is_data  = bit_en && !is_flag && !is_abort && !is_stuff;

    ones_n = ones_q;
    if (bit_en) begin
      if (!bit_in)                           ones_n = '0;
      else if (ones_q != ONES_W'(ABORT_RUN)) ones_n = ones_q + 1'b1;
    end

    occ_n = occ_q;
    dl_n  = dl_q;
    if (is_flag || is_abort) begin
      occ_n = '0;
    end else if (is_data) begin
      dl_n = {dl_q[DL_LEN-2:0], bit_in};
      if (occ_q != OCC_W'(DL_LEN)) occ_n = occ_q + 1'b1;
    end

    dv_n = is_data && (occ_q == OCC_W'(DL_LEN));
    db_n = dl_q[DL_LEN-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= '0;
      occ_q     <= '0;
      dl_q      <= '0;
      d_valid   <= 1'b0;
      d_bit     <= 1'b0;
      flag_evt  <= 1'b0;
      abort_evt <= 1'b0;
    end else if (sync_clr) begin
      ones_q    <= '0;
      occ_q     <= '0;
      dl_q      <= '0;
      d_valid   <= 1'b0;
      d_bit     <= 1'b0;
      flag_evt  <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      ones_q    <= ones_n;
      occ_q     <= occ_n;
      dl_q      <= dl_n;
      d_valid   <= dv_n;
      d_bit     <= db_n;
      flag_evt  <= is_flag;
      abort_evt <= is_abort;
    end
  end

  AST_STUFF_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bit_in && !sync_clr && ones_q == ONES_W'(STUFF_RUN)) |=> !d_valid); // R3
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt); // R7
  AST_FLAG_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_evt && d_valid)); // R3

endmodule

// File: rtl/hdlc_rx_fcs.sv
// Bit-serial reflected CRC register.
module hdlc_rx_fcs #(
  parameter int          FCS_W    = 16,
  parameter logic [15:0] FCS_POLY = 16'h8408
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic             bit_in,
  output logic [FCS_W-1:0] crc_q
);
  localparam logic [FCS_W-1:0] POLY_R = FCS_W'(FCS_POLY);

  logic [FCS_W-1:0] crc_n;
  logic             fb;

  always_comb begin
    fb    = crc_q[0] ^ bit_in;
    crc_n = crc_q;
    if (init)    crc_n = '1;
    else if (en) crc_n = (crc_q >> 1) ^ (fb ? POLY_R : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          STUFF_RUN   = 5,
  parameter int          FCS_W       = 16,
  parameter logic [15:0] FCS_POLY    = 16'h8408,
  parameter logic [15:0] FCS_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_reset_ctl,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_data,
  input  logic              sts_clear,
  output logic              sts_start,
  output logic              sts_end,
  output logic [1:0]        end_code
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              ctl_q, ctl_rise;
  logic              d_valid, d_bit, flag_evt, abort_evt;
  logic [FCS_W-1:0]  crc_q;

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  bcnt_q, bcnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, sh_shift;
  logic              got_q, got_n;
  logic              wr_q, wr_n;
  logic [BYTE_W-1:0] wd_q, wd_n;
  logic              start_q, start_n, end_q, end_n;
  end_code_e         code_q, code_n;

  assign ctl_rise = rx_reset_ctl && !ctl_q;

  hdlc_rx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (ctl_rise),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .d_valid   (d_valid),
    .d_bit     (d_bit),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt)
  );

  hdlc_rx_fcs #(.FCS_W(FCS_W), .FCS_POLY(FCS_POLY)) u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (ctl_rise || flag_evt),
    .en     (d_valid && st_q == ST_FRAME),
    .bit_in (d_bit),
    .crc_q  (crc_q)
  );

  always_comb begin
    st_n     = st_q;
    bcnt_n   = bcnt_q;
    sh_n     = sh_q;
    got_n    = got_q;
    wr_n     = 1'b0;
    wd_n     = wd_q;
    start_n  = start_q;
    end_n    = end_q;
    code_n   = code_q;
    sh_shift = {d_bit, sh_q[BYTE_W-1:1]};

    if (ctl_rise) begin
      st_n    = ST_HUNT;
      bcnt_n  = '0;
      got_n   = 1'b0;
      start_n = 1'b0;
      end_n   = 1'b0;
      code_n  = END_GOOD;
    end else begin
      if (sts_clear) begin
        start_n = 1'b0;
        end_n   = 1'b0;
      end
      unique case (st_q)
        ST_HUNT: begin
          if (flag_evt) begin
            st_n    = ST_FRAME;
            bcnt_n  = '0;
            got_n   = 1'b0;
            start_n = 1'b1;
          end
        end
        ST_FRAME: begin
          if (flag_evt) begin
            bcnt_n = '0;
            if (got_q) begin
              end_n  = 1'b1;
              code_n = (bcnt_q == '0 && crc_q == FCS_W'(FCS_RESIDUE)) ? END_GOOD : END_CRC;
              st_n   = ST_HUNT;
            end
          end else if (abort_evt) begin
            st_n = ST_HUNT;
            if (got_q) begin
              end_n  = 1'b1;
              code_n = END_ABT;
            end
          end else if (d_valid) begin
            got_n = 1'b1;
            sh_n  = sh_shift;
            if (bcnt_q == CNT_W'(BYTE_W - 1)) begin
              bcnt_n = '0;
              if (fifo_full) begin
                end_n  = 1'b1;
                code_n = END_OVR;
                st_n   = ST_DROP;
              end else begin
                wr_n = 1'b1;
                wd_n = sh_shift;
              end
            end else begin
              bcnt_n = bcnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (flag_evt || abort_evt) st_n = ST_HUNT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= 1'b0;
      st_q    <= ST_HUNT;
      bcnt_q  <= '0;
      sh_q    <= '0;
      got_q   <= 1'b0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      code_q  <= END_GOOD;
    end else begin
      ctl_q   <= rx_reset_ctl;
      st_q    <= st_n;
      bcnt_q  <= bcnt_n;
      sh_q    <= sh_n;
      got_q   <= got_n;
      wr_q    <= wr_n;
      wd_q    <= wd_n;
      start_q <= start_n;
      end_q   <= end_n;
      code_q  <= code_n;
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_data = wd_q;
  assign sts_start = start_q;
  assign sts_end   = end_q;
  assign end_code  = code_q;

  AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(!fifo_full)); // R6
  AST_OVR_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_end) && end_code == 2'd2) |-> $past(fifo_full)); // R6
  AST_START_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_start) |-> $past(flag_evt)); // R2
  AST_STICKY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_start) |-> $past(sts_clear || ctl_rise)); // R8
  AST_STICKY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_end) |-> $past(sts_clear || ctl_rise)); // R8
  AST_CTL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rise |=> (!sts_start && !sts_end && !fifo_wr)); // R9

endmodule

// File: tb/hdlc_rx_ctrl_tb.sv
module hdlc_rx_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, rx_reset_ctl, bit_en, bit_in, fifo_full, sts_clear;
  logic       fifo_wr, sts_start, sts_end;
  logic [7:0] fifo_data;
  logic [1:0] end_code;

  int n_chk = 0;
  int n_fail = 0;
  int ones = 0;
  int ncap = 0;
  logic [7:0] cap [16];
  bit done = 1'b0;

  // payload b0,b1,b2 | corrupt FCS | expected end code
  localparam logic [26:0] VEC [4] = '{
    {8'h12, 8'h34, 8'h56, 1'b0, 2'd0},
    {8'hFF, 8'h7E, 8'hF8, 1'b0, 2'd0},
    {8'hA5, 8'h00, 8'h5A, 1'b1, 2'd1},
    {8'h3E, 8'hFF, 8'h1F, 1'b0, 2'd0}
  };

  always #2 clk = ~clk;

  hdlc_rx_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_reset_ctl (rx_reset_ctl),
    .bit_en       (bit_en),
    .bit_in       (bit_in),
    .fifo_full    (fifo_full),
    .fifo_wr      (fifo_wr),
    .fifo_data    (fifo_data),
    .sts_clear    (sts_clear),
    .sts_start    (sts_start),
    .sts_end      (sts_end),
    .end_code     (end_code)
  );

  always @(negedge clk) begin
    if (rst_n && fifo_wr && ncap < 16) begin
      cap[ncap] = fifo_data;
      ncap++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit((i == 0 || i == 7) ? 1'b0 : 1'b1);
    ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) ones++; else ones = 0;
      if (ones == 5) begin
        send_bit(1'b0);
        ones = 0;
      end
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    sts_clear = 1'b1;
    @(negedge clk);
    sts_clear = 1'b0;
  endtask

  function automatic logic [15:0] crc3(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] c);
    logic [15:0] r;
    logic [7:0]  by;
    logic        fb;
    r = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin
      by = (i == 0) ? a : (i == 1) ? b : c;
      for (int j = 0; j < 8; j++) begin
        fb = r[0] ^ by[j];
        r  = r >> 1;
        if (fb) r = r ^ 16'h8408;
      end
    end
    return r;
  endfunction

  task automatic send_frame(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input logic bad, output logic [15:0] fcs);
    fcs = ~crc3(a, b, c);
    if (bad) fcs[0] = ~fcs[0];
    ncap = 0;
    send_flag();
    send_byte(a);
    send_byte(b);
    send_byte(c);
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
    send_flag();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] fcs;
    rst_n = 1'b0; rx_reset_ctl = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    fifo_full = 1'b0; sts_clear = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", sts_start, 0);
    chk("R1 end in reset", sts_end, 0);
    chk("R1 wr in reset", fifo_wr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 start after reset", sts_start, 0);
    chk("R1 code after reset", end_code, 0);

    // table of frames: R2 R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      pulse_clear();
      send_frame(VEC[v][26:19], VEC[v][18:11], VEC[v][10:3], VEC[v][2], fcs);
      chk("R2 start on flag", sts_start, 1);
      chk("R4 R5 end set", sts_end, 1);
      chk("R4 R5 end code", end_code, VEC[v][1:0]);
      chk("R3 byte count", ncap, 5);
      chk("R3 byte 0", cap[0], VEC[v][26:19]);
      chk("R3 byte 1", cap[1], VEC[v][18:11]);
      chk("R3 byte 2", cap[2], VEC[v][10:3]);
      chk("R3 fcs lo", cap[3], fcs[7:0]);
      chk("R3 fcs hi", cap[4], fcs[15:8]);
    end

    // R8 sticky, then cleared
    repeat (20) @(negedge clk);
    chk("R8 start sticky", sts_start, 1);
    chk("R8 end sticky", sts_end, 1);
    pulse_clear();
    @(negedge clk);
    chk("R8 start cleared", sts_start, 0);
    chk("R8 end cleared", sts_end, 0);

    // R7 idle ones give no event
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    chk("R7 idle no start", sts_start, 0);
    chk("R7 idle no end", sts_end, 0);

    // R7 abort inside a frame
    send_flag();
    send_byte(8'h55);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    chk("R7 abort end", sts_end, 1);
    chk("R7 abort code", end_code, 3);

    // R6 overrun
    pulse_clear();
    fifo_full = 1'b1;
    send_frame(8'h01, 8'h02, 8'h03, 1'b0, fcs);
    chk("R6 overrun end", sts_end, 1);
    chk("R6 overrun code", end_code, 2);
    chk("R6 nothing written", ncap, 0);
    fifo_full = 1'b0;

    // R9 rising edge resets, held level does not
    pulse_clear();
    send_flag();
    send_byte(8'h11);
    chk("R9 start before reset", sts_start, 1);
    @(negedge clk);
    rx_reset_ctl = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 start cleared by edge", sts_start, 0);
    send_frame(8'hC3, 8'h81, 8'h7F, 1'b0, fcs);
    chk("R9 level ignored end", sts_end, 1);
    chk("R9 level ignored code", end_code, 0);
    chk("R9 level ignored bytes", ncap, 5);
    rx_reset_ctl = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule